// File: doc/BRIEF.md
# Translated Direct-Mapped Cache Lookup

This block serves loads and stores that carry a 20-bit virtual byte address. The virtual page number is looked up in a small, fully searched translation buffer. The buffer supplies a physical page number and two page flags: store permission and dirty. The physical address that results indexes a direct-mapped data cache of sixteen four-word lines. Each request gets exactly one response: a hit with the selected 32-bit word, a cache miss, a translation miss, or a protection fault.

Software owns the translation buffer. It writes whole entries through a write port and reads back each entry's dirty flag, so it can decide whether a page must be written back before the page is reused. Hardware only ever sets dirty flags. It never clears them, and it never touches store permission. When a lookup finds no entry, the block only raises a miss, and software loads the entry.

Cache lines are loaded through a fill port. A small sequencer opens a line with its set and tag, accepts the four words in order, and marks the line valid after the last word. The sequencer has two states. `FS_IDLE` is the rest state. `FS_FILL` is entered on a fill start (transition GO_FILL). It stays in `FS_FILL` for each accepted word (NEXT_WORD) and on a fresh fill start (RESTART). It returns to `FS_IDLE` on the fourth word (LAST_WORD).

Top module: `xlat_dcache`

## Requirements
- R1: A request is sampled on a rising edge with `req_valid` high. Its response is registered and is visible from that edge until the next one, with `rsp_valid` high. `rsp_valid`, `rsp_hit`, `rsp_tlb_miss` and `rsp_prot_fault` are all low one cycle after an edge at which no request was presented.
- R2: The virtual page number is `req_vaddr[19:12]` and is compared against all valid entries. On a match, the physical address is `{ppn, req_vaddr[11:0]}`. With no match, `rsp_tlb_miss` is 1, `rsp_hit` is 0, and neither the cache nor any dirty flag changes.
- R3: The physical address is split into fields: bits [7:4] pick the set, bits [3:2] pick the word, and bits [15:8] are the tag. Bits [1:0] are ignored. A load hits only when the set's line is valid and its stored tag equals the tag field. A load hit returns the word on `rsp_rdata`. Every other outcome returns 0.
- R4: A translated store to a page with store permission sets that entry's dirty flag. On a cache hit, the store writes `req_wdata` into the addressed word and reports `rsp_hit`. On a cache miss, it reports `rsp_hit` 0 and allocates no line.
- R5: A store to a page without store permission raises `rsp_prot_fault`. It leaves the cache data and the dirty flag unchanged. Loads from that page are served normally.
- R6: At most one of `rsp_hit`, `rsp_tlb_miss` and `rsp_prot_fault` is high at a time, and `rsp_prot_fault` is raised only for stores.
- R7: A pulse on `tlbw_en` loads the entry at `tlbw_idx` with page number, frame number, valid, store permission and dirty. If a store marks the same entry in the same cycle, the software value wins. Hardware never clears a dirty flag.
- R8: `dq_dirty` shows, without a clock delay, the dirty flag of the entry at `dq_idx`.
- R9: If several valid entries hold the same page number, the entry with the lowest index supplies the translation.
- R10: A `fill_start` pulse with `fill_set` and `fill_tag` invalidates that line and stores its tag. The next four cycles with `fill_we` high write words 0 to 3 in order. The line becomes valid after the fourth word, and lookups to it miss until then. A new `fill_start` during a fill restarts the fill at word 0.
- R11: Reset (synchronous, active high) clears every entry's valid, store permission and dirty flag, clears every cache valid bit, and puts the sequencer in `FS_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_vaddr | input | 20 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translated, permitted and line hit |
| rsp_tlb_miss | output | 1 | No valid entry matched |
| rsp_prot_fault | output | 1 | Store to a page without store permission |
| rsp_rdata | output | 32 | Load data on a hit, else 0 |
| tlbw_en | input | 1 | Write one translation entry |
| tlbw_idx | input | 2 | Entry index to write |
| tlbw_vpn | input | 8 | Virtual page number |
| tlbw_ppn | input | 4 | Physical page number |
| tlbw_valid | input | 1 | Entry valid flag |
| tlbw_wen | input | 1 | Store permission flag |
| tlbw_dirty | input | 1 | Dirty flag value |
| dq_idx | input | 2 | Entry whose dirty flag is shown |
| dq_dirty | output | 1 | Dirty flag of entry `dq_idx` |
| fill_start | input | 1 | Open a line for refill |
| fill_set | input | 4 | Set to refill |
| fill_tag | input | 8 | Tag of the line being loaded |
| fill_we | input | 1 | Refill word valid |
| fill_data | input | 32 | Refill word |

## Verification
Every lookup result, including the side effects of a store on cache data and dirty flags, takes effect at the rising edge that samples the request. The bench drives each request on a falling edge and reads the response at the next falling edge, half a cycle after the edge that registers it. Dirty flags are read 1 ns after `dq_idx` changes, because that path has no register. Cache and dirty side effects are confirmed with a later lookup or readback, never within the same cycle. A refilled line is probed only after the falling edge that follows its fourth word, and a mid-fill probe falls between the second and third words.

// File: rtl/xdc_pkg.sv
package xdc_pkg;

    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_state_e;

endpackage

// File: rtl/xdc_xlat.sv
module xdc_xlat #(
    parameter int VPN_W   = 8,
    parameter int PPN_W   = 4,
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wen,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [VPN_W-1:0] sw_vpn,
    input  logic [PPN_W-1:0] sw_ppn,
    input  logic             sw_valid,
    input  logic             sw_wen,
    input  logic             sw_dirty,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_dirty,
    output logic [ENTRIES-1:0] dirty_vec
);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] wen_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    // Search from the top so the lowest matching index is the one kept.
    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid_q[i] && (vpn_q[i] == lk_vpn)) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
        end
    end

    assign lk_ppn    = ppn_q[lk_idx];
    assign lk_wen    = wen_q[lk_idx];
    assign rd_dirty  = dirty_q[rd_idx];
    assign dirty_vec = dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            wen_q   <= '0;
            dirty_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (sw_we && (sw_idx == IDX_W'(i))) begin
                    valid_q[i] <= sw_valid;
                    wen_q[i]   <= sw_wen;
                    dirty_q[i] <= sw_dirty;
                    vpn_q[i]   <= sw_vpn;
                    ppn_q[i]   <= sw_ppn;
                end else if (mark_en && (mark_idx == IDX_W'(i))) begin
                    dirty_q[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xdc_lines.sv
module xdc_lines #(
    parameter int SET_W  = 4,
    parameter int WSEL_W = 2,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WSEL_W-1:0] rd_word,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              st_en,
    input  logic [SET_W-1:0]  st_set,
    input  logic [WSEL_W-1:0] st_word,
    input  logic [DATA_W-1:0] st_data,
    input  logic              ln_open,
    input  logic [SET_W-1:0]  ln_set,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic              wd_en,
    input  logic [WSEL_W-1:0] wd_idx,
    input  logic [DATA_W-1:0] wd_data,
    input  logic              ln_close
);

    localparam int SETS   = 1 << SET_W;
    localparam int CELL_W = SET_W + WSEL_W;
    localparam int CELLS  = 1 << CELL_W;

    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] mem_q [CELLS];

    assign rd_vld  = vld_q[rd_set];
    assign rd_tag  = tag_q[rd_set];
    assign rd_data = mem_q[{rd_set, rd_word}];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (ln_open) begin
            vld_q[ln_set] <= 1'b0;
        end else if (ln_close) begin
            vld_q[ln_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ln_open) begin
            tag_q[ln_set] <= ln_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wd_en) begin
            mem_q[{ln_set, wd_idx}] <= wd_data;
        end else if (st_en) begin
            mem_q[{st_set, st_word}] <= st_data;
        end
    end

endmodule

// File: rtl/xdc_refill.sv
module xdc_refill
    import xdc_pkg::*;
#(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 8,
    parameter int WSEL_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_start,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_we,
    input  logic [DATA_W-1:0] fill_data,
    output logic              ln_open,
    output logic [SET_W-1:0]  ln_set,
    output logic [TAG_W-1:0]  ln_tag,
    output logic              wd_en,
    output logic [WSEL_W-1:0] wd_idx,
    output logic [DATA_W-1:0] wd_data,
    output logic              ln_close
);

    localparam logic [WSEL_W-1:0] LAST_WORD = '1;

    fill_state_e       state_q, state_d;
    logic [SET_W-1:0]  set_q;
    logic [WSEL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            set_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fill_start) begin
                set_q <= fill_set;
                cnt_q <= '0;
            end else if (wd_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d  = state_q;
        ln_open  = fill_start;
        ln_set   = fill_start ? fill_set : set_q;
        ln_tag   = fill_tag;
        wd_en    = 1'b0;
        wd_idx   = cnt_q;
        wd_data  = fill_data;
        ln_close = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                if (fill_start) begin
                    state_d = FS_FILL;               // GO_FILL
                end
            end
            FS_FILL: begin
                if (fill_start) begin
                    state_d = FS_FILL;               // RESTART
                end else if (fill_we) begin
                    wd_en = 1'b1;                    // NEXT_WORD
                    if (cnt_q == LAST_WORD) begin
                        ln_close = 1'b1;
                        state_d  = FS_IDLE;          // LAST_WORD
                    end
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

endmodule

// File: rtl/xlat_dcache.sv
module xlat_dcache #(
    parameter int VADDR_W     = 20,
    parameter int PAGE_W      = 12,
    parameter int PADDR_W     = 16,
    parameter int TLB_ENTRIES = 4,
    parameter int SETS        = 16,
    parameter int LINE_WORDS  = 4,
    parameter int DATA_W      = 32,
    localparam int VPN_W  = VADDR_W - PAGE_W,
    localparam int PPN_W  = PADDR_W - PAGE_W,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int WSEL_W = $clog2(LINE_WORDS),
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = PADDR_W - SET_W - WSEL_W - BYTE_W,
    localparam int IDX_W  = $clog2(TLB_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [VADDR_W-1:0] req_vaddr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_tlb_miss,
    output logic               rsp_prot_fault,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic               tlbw_en,
    input  logic [IDX_W-1:0]   tlbw_idx,
    input  logic [VPN_W-1:0]   tlbw_vpn,
    input  logic [PPN_W-1:0]   tlbw_ppn,
    input  logic               tlbw_valid,
    input  logic               tlbw_wen,
    input  logic               tlbw_dirty,
    input  logic [IDX_W-1:0]   dq_idx,
    output logic               dq_dirty,
    input  logic               fill_start,
    input  logic [SET_W-1:0]   fill_set,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               fill_we,
    input  logic [DATA_W-1:0]  fill_data
);

    logic                   lk_hit, lk_wen;
    logic [IDX_W-1:0]       lk_idx;
    logic [PPN_W-1:0]       lk_ppn;
    logic [PADDR_W-1:0]     paddr;
    logic [SET_W-1:0]       pa_set;
    logic [WSEL_W-1:0]      pa_word;
    logic [TAG_W-1:0]       pa_tag;
    logic                   rd_vld;
    logic [TAG_W-1:0]       rd_tag;
    logic [DATA_W-1:0]      rd_data;
    logic                   line_hit, store_ok, fault_now;
    logic [TLB_ENTRIES-1:0] pg_dirty;
    logic                   ln_open, wd_en, ln_close;
    logic [SET_W-1:0]       ln_set;
    logic [TAG_W-1:0]       ln_tag;
    logic [WSEL_W-1:0]      wd_idx;
    logic [DATA_W-1:0]      wd_data;
    logic                   unused_byte_sel;

    assign unused_byte_sel = ^paddr[BYTE_W-1:0];

    xdc_xlat #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(TLB_ENTRIES), .IDX_W(IDX_W)
    ) u_xlat (
        .clk(clk), .rst(rst),
        .lk_vpn(req_vaddr[VADDR_W-1:PAGE_W]),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_wen(lk_wen),
        .mark_en(store_ok), .mark_idx(lk_idx),
        .sw_we(tlbw_en), .sw_idx(tlbw_idx), .sw_vpn(tlbw_vpn), .sw_ppn(tlbw_ppn),
        .sw_valid(tlbw_valid), .sw_wen(tlbw_wen), .sw_dirty(tlbw_dirty),
        .rd_idx(dq_idx), .rd_dirty(dq_dirty), .dirty_vec(pg_dirty)
    );

    assign paddr   = {lk_ppn, req_vaddr[PAGE_W-1:0]};
    assign pa_word = paddr[BYTE_W +: WSEL_W];
    assign pa_set  = paddr[BYTE_W + WSEL_W +: SET_W];
    assign pa_tag  = paddr[PADDR_W-1 -: TAG_W];

    assign line_hit  = lk_hit && rd_vld && (rd_tag == pa_tag);
    assign fault_now = req_valid && req_store && lk_hit && !lk_wen;
    assign store_ok  = req_valid && req_store && lk_hit && lk_wen;

    xdc_refill #(
        .SET_W(SET_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)
    ) u_refill (
        .clk(clk), .rst(rst),
        .fill_start(fill_start), .fill_set(fill_set), .fill_tag(fill_tag),
        .fill_we(fill_we), .fill_data(fill_data),
        .ln_open(ln_open), .ln_set(ln_set), .ln_tag(ln_tag),
        .wd_en(wd_en), .wd_idx(wd_idx), .wd_data(wd_data), .ln_close(ln_close)
    );

    xdc_lines #(
        .SET_W(SET_W), .WSEL_W(WSEL_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst(rst),
        .rd_set(pa_set), .rd_word(pa_word),
        .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_data(rd_data),
        .st_en(store_ok && line_hit), .st_set(pa_set), .st_word(pa_word),
        .st_data(req_wdata),
        .ln_open(ln_open), .ln_set(ln_set), .ln_tag(ln_tag),
        .wd_en(wd_en), .wd_idx(wd_idx), .wd_data(wd_data), .ln_close(ln_close)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_tlb_miss   <= 1'b0;
            rsp_prot_fault <= 1'b0;
            rsp_rdata      <= '0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_hit        <= req_valid && line_hit && !fault_now;
            rsp_tlb_miss   <= req_valid && !lk_hit;
            rsp_prot_fault <= fault_now;
            rsp_rdata      <= (req_valid && !req_store && line_hit) ? rd_data : '0;
        end
    end

endmodule

// File: rtl/xlat_dcache_chk.sv
module xlat_dcache_chk #(
    parameter int ENTRIES = 4,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_store,
    input logic               tlbw_en,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_tlb_miss,
    input logic               rsp_prot_fault,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic [ENTRIES-1:0] pg_dirty
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                                    // R1

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_valid || rsp_hit || rsp_tlb_miss || rsp_prot_fault));    // R1

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_tlb_miss, rsp_prot_fault}) <= 1);     // R6

    AST_FAULT_ON_STORE: assert property (@(posedge clk) disable iff (rst)
        rsp_prot_fault |-> $past(req_valid && req_store));                           // R6

    AST_RDATA_ZERO_OFF_HIT: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> rsp_rdata == '0);                                               // R3

    AST_DIRTY_NOT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !tlbw_en |=> (pg_dirty & $past(pg_dirty)) == $past(pg_dirty));               // R7

endmodule

bind xlat_dcache xlat_dcache_chk #(.ENTRIES(TLB_ENTRIES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .tlbw_en(tlbw_en), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_tlb_miss(rsp_tlb_miss), .rsp_prot_fault(rsp_prot_fault),
    .rsp_rdata(rsp_rdata), .pg_dirty(pg_dirty)
);

// File: tb/xlat_dcache_test.sv
`timescale 1ns/1ps
module xlat_dcache_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_store = 0;
    logic [19:0] req_vaddr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_hit, rsp_tlb_miss, rsp_prot_fault;
    logic [31:0] rsp_rdata;
    logic        tlbw_en = 0, tlbw_valid = 0, tlbw_wen = 0, tlbw_dirty = 0;
    logic [1:0]  tlbw_idx = '0, dq_idx = '0;
    logic [7:0]  tlbw_vpn = '0;
    logic [3:0]  tlbw_ppn = '0;
    logic        dq_dirty;
    logic        fill_start = 0, fill_we = 0;
    logic [3:0]  fill_set = '0;
    logic [7:0]  fill_tag = '0;
    logic [31:0] fill_data = '0;

    int n_tests = 0;
    int n_fail  = 0;

    // requirement model
    logic        tv [4];
    logic        twen [4];
    logic        tdirty [4];
    logic [7:0]  tvpn [4];
    logic [3:0]  tppn [4];
    logic        mvld [16];
    logic [7:0]  mtag [16];
    logic [31:0] mdat [16][4];

    always #2.5 clk = ~clk;

    xlat_dcache uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_vaddr(req_vaddr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_tlb_miss(rsp_tlb_miss), .rsp_prot_fault(rsp_prot_fault),
        .rsp_rdata(rsp_rdata), .tlbw_en(tlbw_en), .tlbw_idx(tlbw_idx),
        .tlbw_vpn(tlbw_vpn), .tlbw_ppn(tlbw_ppn), .tlbw_valid(tlbw_valid),
        .tlbw_wen(tlbw_wen), .tlbw_dirty(tlbw_dirty), .dq_idx(dq_idx),
        .dq_dirty(dq_dirty), .fill_start(fill_start), .fill_set(fill_set),
        .fill_tag(fill_tag), .fill_we(fill_we), .fill_data(fill_data)
    );

    function automatic logic [31:0] dat(int s, int w, int seed);
        return {8'(seed), 8'hA5, 8'(s), 8'(w)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tlb_wr(input int i, input logic [7:0] vpn, input logic [3:0] ppn,
                          input bit v, input bit wen, input bit dty);
        @(negedge clk);
        tlbw_en = 1; tlbw_idx = 2'(i); tlbw_vpn = vpn; tlbw_ppn = ppn;
        tlbw_valid = v; tlbw_wen = wen; tlbw_dirty = dty;
        @(negedge clk);
        tlbw_en = 0;
        tv[i] = v; twen[i] = wen; tdirty[i] = dty; tvpn[i] = vpn; tppn[i] = ppn;
    endtask

    task automatic dirty_chk(input int i, input string req);
        dq_idx = 2'(i);
        #1;
        check(dq_dirty == tdirty[i], req, "dirty readback", 32'(dq_dirty), 32'(tdirty[i]));
    endtask

    task automatic fill_open(input int s, input logic [7:0] tg);
        @(negedge clk);
        fill_start = 1; fill_set = 4'(s); fill_tag = tg;
        @(negedge clk);
        fill_start = 0;
        mvld[s] = 0; mtag[s] = tg;
    endtask

    task automatic fill_words(input int s, input int first, input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            fill_we = 1; fill_data = dat(s, first + k, seed);
            @(negedge clk);
            mdat[s][first + k] = dat(s, first + k, seed);
            if (first + k == 3) mvld[s] = 1;
        end
        fill_we = 0;
    endtask

    // Drive one lookup, predict its outcome from the model, compare, update the model.
    task automatic probe(input bit st, input logic [19:0] va, input logic [31:0] wd,
                         input string req);
        bit found = 0;
        int e = 0;
        logic [15:0] pa;
        int s, w;
        bit lh;
        logic [3:0] exp_flags;
        logic [31:0] exp_rd = '0;
        for (int i = 0; i < 4; i++)
            if (!found && tv[i] && tvpn[i] == va[19:12]) begin found = 1; e = i; end
        if (!found) begin
            exp_flags = 4'b1010;                      // valid, hit, tlb_miss, fault
        end else begin
            pa = {tppn[e], va[11:0]};
            s = int'(pa[7:4]); w = int'(pa[3:2]);
            lh = mvld[s] && (mtag[s] == pa[15:8]);
            if (st && !twen[e]) begin
                exp_flags = 4'b1001;
            end else begin
                exp_flags = {1'b1, lh, 2'b00};
                if (st) begin
                    tdirty[e] = 1;
                    if (lh) mdat[s][w] = wd;
                end else if (lh) begin
                    exp_rd = mdat[s][w];
                end
            end
        end
        @(negedge clk);
        req_valid = 1; req_store = st; req_vaddr = va; req_wdata = wd;
        @(negedge clk);
        req_valid = 0; req_store = 0;
        check({rsp_valid, rsp_hit, rsp_tlb_miss, rsp_prot_fault} == exp_flags, req,
              "flags v/h/m/f", 32'({rsp_valid, rsp_hit, rsp_tlb_miss, rsp_prot_fault}),
              32'(exp_flags));
        check(rsp_rdata == exp_rd, req, "rdata", rsp_rdata, exp_rd);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            tv[i] = 0; twen[i] = 0; tdirty[i] = 0; tvpn[i] = '0; tppn[i] = '0;
        end
        for (int s = 0; s < 16; s++) begin
            mvld[s] = 0; mtag[s] = '0;
            for (int w = 0; w < 4; w++) mdat[s][w] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 0;

        // R11: reset state
        for (int i = 0; i < 4; i++) dirty_chk(i, "R11");
        probe(0, 20'h12345, '0, "R11");
        tlb_wr(0, 8'h05, 4'hB, 1, 1, 0);
        tlb_wr(1, 8'h3C, 4'h2, 1, 0, 0);
        tlb_wr(2, 8'h77, 4'hB, 1, 1, 0);
        probe(0, 20'h05540, '0, "R11");          // translated, cache empty

        // R1: response lasts one cycle
        @(negedge clk);
        check(!rsp_valid && !rsp_hit && !rsp_tlb_miss, "R1", "idle response",
              32'({rsp_valid, rsp_hit, rsp_tlb_miss}), 32'h0);

        // R10: load all lines
        for (int s = 0; s < 16; s++) begin
            fill_open(s, (s < 8) ? 8'hB5 : 8'h2A);
            fill_words(s, 0, 4, 1);
        end

        // R2 R3: sweep pages, tag offsets, sets, words; low byte bits vary
        foreach (tvpn[k]) begin end
        for (int p = 0; p < 4; p++) begin
            for (int h = 0; h < 3; h++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int w = 0; w < 4; w++) begin
                        logic [7:0] vp;
                        logic [3:0] hi;
                        vp = (p == 0) ? 8'h05 : (p == 1) ? 8'h77 : (p == 2) ? 8'h3C : 8'h99;
                        hi = (h == 0) ? 4'h5 : (h == 1) ? 4'hA : 4'h2;
                        probe(0, {vp, hi, 4'(s), 2'(w), 2'(s + w)}, '0,
                              (p == 3) ? "R2" : "R3");
                    end
                end
            end
        end

        // R10: mid-fill miss, then completion
        fill_open(3, 8'hB5);
        fill_words(3, 0, 2, 9);
        probe(0, 20'h05530, '0, "R10");
        fill_words(3, 2, 2, 9);
        for (int w = 0; w < 4; w++) probe(0, {12'h055, 4'h3, 2'(w), 2'b00}, '0, "R10");
        // R10: restart
        fill_open(5, 8'hB5);
        fill_words(5, 0, 1, 7);
        fill_open(5, 8'hB5);
        fill_words(5, 0, 4, 8);
        for (int w = 0; w < 4; w++) probe(0, {12'h055, 4'h5, 2'(w), 2'b00}, '0, "R10");

        // R5: protection fault leaves cache and dirty alone
        probe(1, 20'h3CA94, 32'hDEAD_BEEF, "R5");
        probe(0, 20'h3CA94, '0, "R5");
        dirty_chk(1, "R5");

        // R4: store hit writes and dirties; store miss only dirties
        probe(1, 20'h05524, 32'h1234_5678, "R4");
        probe(0, 20'h05524, '0, "R4");
        dirty_chk(0, "R4");
        dirty_chk(2, "R4");
        probe(1, 20'h77700, 32'hCAFE_F00D, "R4");
        dirty_chk(2, "R4");
        probe(0, 20'h77700, '0, "R4");
        probe(0, 20'h05500, '0, "R4");

        // R7: software write wins over same-cycle hardware mark
        @(negedge clk);
        tlbw_en = 1; tlbw_idx = 2'd0; tlbw_vpn = 8'h05; tlbw_ppn = 4'hB;
        tlbw_valid = 1; tlbw_wen = 1; tlbw_dirty = 0;
        req_valid = 1; req_store = 1; req_vaddr = 20'h05700; req_wdata = 32'h0;
        @(negedge clk);
        tlbw_en = 0; req_valid = 0; req_store = 0;
        tdirty[0] = 0;
        check({rsp_hit, rsp_prot_fault, rsp_tlb_miss} == 3'b000, "R7", "store flags",
              32'({rsp_hit, rsp_prot_fault, rsp_tlb_miss}), 32'h0);
        dirty_chk(0, "R7");
        // R8: readback tracks index with no clock
        dirty_chk(2, "R8");
        dirty_chk(0, "R8");

        // R9: duplicate page number, lowest index wins
        tlb_wr(3, 8'h05, 4'h2, 1, 0, 0);
        probe(0, 20'h05514, '0, "R9");
        probe(1, 20'h05514, 32'h0BAD_0001, "R9");
        tlb_wr(0, 8'h05, 4'hB, 0, 1, 0);
        probe(0, 20'h05514, '0, "R9");
        probe(1, 20'h05514, 32'h0BAD_0002, "R9");
        dirty_chk(3, "R9");

        // R6: outcomes stay exclusive on a final mix
        probe(1, 20'h99000, 32'h1, "R6");
        probe(1, 20'h3CA80, 32'h2, "R6");

        finish_run();
    end

endmodule